// File: doc/BRIEF.md
# Latched Parallel Port with Service Request

This block is a byte-wide parallel port for a processor bus, built as a clocked equivalent of a strobed latch. A register holds one data byte and drives it onto the bus through an output stage with a single common enable. A service-request flag produces an active-low interrupt that a priority circuit downstream can read. Two select lines decode device selection. A mode line picks where the load control and the output enable come from. A strobe both loads data (in input mode) and, on its falling edge, raises the interrupt. An active-low clear empties the byte and retires the request.

All inputs are sampled on the rising clock edge. Every output is registered and shows the effect of the inputs sampled at that same edge. In output mode the stage is always enabled, and the byte follows the data inputs while the device is selected. In input mode a peripheral strobes data in, the interrupt tells the processor, and the processor selects the device to read the byte. When the stage is disabled the data pins read all zeros and the enable is low, so a wrapper can turn them into a true high-impedance bus.

Top module: `latched_port`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `dout` = 0, `dout_en` = 0 and `irq_n` = 1. The held byte is zero and the request flag is set.
- R2: The device counts as selected only when `sel_lo` = 0 and `sel_hi` = 1. Any other pair of values leaves it unselected.
- R3: With `mode_out` = 1, `dout_en` is 1 after every edge, and the load control is the device-select term. While the device is selected, `dout` equals `din` sampled at the same edge.
- R4: With `mode_out` = 0, `dout_en` equals the device-select term, and the load control is `strobe`. When `strobe` = 1 the byte is loaded from `din`, and it appears on `dout` once the stage is enabled.
- R5: While the load control is 0 and `clr_n` = 1, the held byte keeps its value from edge to edge, whatever `din` does.
- R6: `clr_n` = 0 while the load control is 0 makes the held byte zero. When the load control is 1, `din` is loaded instead of zero (the load overrides the clear).
- R7: After any edge where the stage is disabled, `dout_en` = 0 and `dout` = 0.
- R8: The request flag is set after any edge where `clr_n` = 0 or the device is selected. `irq_n` is 1 exactly when the flag is set and the device is not selected.
- R9: A strobe falling edge is `strobe` = 1 at one edge and 0 at the next. Such an edge clears the request flag when no set condition is present, so `irq_n` = 0 after that edge.
- R10: If a set condition (`clr_n` = 0 or device selected) is present at the same edge as a strobe falling edge, the flag stays set.
- R11: `irq_n` = 0 after any edge where the device is selected, whatever the state of the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_lo | input | 1 | Select line that must be low to select |
| sel_hi | input | 1 | Select line that must be high to select |
| mode_out | input | 1 | 1 = output mode, 0 = input mode |
| strobe | input | 1 | Load control in input mode; its falling edge raises the request |
| clr_n | input | 1 | Active-low clear of the byte; sets the request flag |
| din | input | W | Data byte in |
| dout | output | W | Data byte out, zero while disabled |
| dout_en | output | 1 | Output stage enable |
| irq_n | output | 1 | Active-low service request |

## Verification
Every result is due one edge after its stimulus. Data, enable and interrupt all reflect the inputs sampled at that edge. The only history involved is the strobe level from the previous edge, which is used to detect a falling edge. The bench changes inputs on the falling clock edge and compares all three outputs 1 ns after the next rising edge against a model updated at that edge. Directed runs cover each corner first, and then a pseudo-random sweep walks through all 32 control combinations with changing data.

// File: rtl/latched_port_pkg.sv
package latched_port_pkg;
  parameter int PORT_W = 8;

  typedef struct packed {
    logic sel;   // device select term
    logic ld;    // load control for the held byte
    logic oe;    // output stage enable
  } port_ctl_t;
endpackage

// File: rtl/lp_ctl_decode.sv
module lp_ctl_decode
  import latched_port_pkg::*;
(
  input  logic      sel_lo,
  input  logic      sel_hi,
  input  logic      mode_out,
  input  logic      strobe,
  output port_ctl_t ctl
);
  logic sel;

  assign sel = ~sel_lo & sel_hi;

  always_comb begin
    ctl.sel = sel;
    if (mode_out) begin
      ctl.ld = sel;
      ctl.oe = 1'b1;
    end else begin
      ctl.ld = strobe;
      ctl.oe = sel;
    end
  end
endmodule

// File: rtl/lp_hold_reg.sv
module lp_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         clr_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);
  logic [W-1:0] q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign nxt[b] = ld ? din[b] : (clr_n & q[b]);

    always_ff @(posedge clk) begin
      if (rst) q[b] <= 1'b0;
      else     q[b] <= nxt[b];
    end
  end
endmodule

// File: rtl/lp_req_flag.sv
module lp_req_flag (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic set_req,
  output logic nxt
);
  logic stb_prev;
  logic flag_q;
  logic fall;

  assign fall = stb_prev & ~strobe;

  always_comb begin
    if (set_req)   nxt = 1'b1;
    else if (fall) nxt = 1'b0;
    else           nxt = flag_q;
  end

  always_ff @(posedge clk) begin
    stb_prev <= strobe;
    if (rst) flag_q <= 1'b1;
    else     flag_q <= nxt;
  end
endmodule

// File: rtl/latched_port.sv
module latched_port
  import latched_port_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_lo,
  input  logic         sel_hi,
  input  logic         mode_out,
  input  logic         strobe,
  input  logic         clr_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_en,
  output logic         irq_n
);
  localparam logic [W-1:0] IDLE_BUS = '0;

  port_ctl_t    ctl;
  logic [W-1:0] byte_nxt;
  logic         flag_nxt;
  logic         set_req;

  lp_ctl_decode u_dec (
    .sel_lo   (sel_lo),
    .sel_hi   (sel_hi),
    .mode_out (mode_out),
    .strobe   (strobe),
    .ctl      (ctl)
  );

  lp_hold_reg #(.W(W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .ld    (ctl.ld),
    .clr_n (clr_n),
    .din   (din),
    .nxt   (byte_nxt)
  );

  assign set_req = ~clr_n | ctl.sel;

  lp_req_flag u_req (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .set_req (set_req),
    .nxt     (flag_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= IDLE_BUS;
      dout_en <= 1'b0;
      irq_n   <= 1'b1;
    end else begin
      dout    <= ctl.oe ? byte_nxt : IDLE_BUS;
      dout_en <= ctl.oe;
      irq_n   <= flag_nxt & ~ctl.sel;
    end
  end
endmodule

// File: rtl/latched_port_chk.sv
module latched_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_lo,
  input logic         sel_hi,
  input logic         mode_out,
  input logic         strobe,
  input logic         clr_n,
  input logic [W-1:0] dout,
  input logic         dout_en,
  input logic         irq_n
);
  AST_SEL_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
    (!sel_lo && sel_hi) |=> !irq_n); // R11

  AST_OUT_MODE_EN: assert property (@(posedge clk) disable iff (rst)
    mode_out |=> dout_en); // R3

  AST_IN_MODE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!mode_out && !(!sel_lo && sel_hi)) |=> !dout_en); // R4

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mode_out && !(!sel_lo && sel_hi) && clr_n && dout_en) |=> $stable(dout)); // R5

  AST_CLR_SETS: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !(!sel_lo && sel_hi)) |=> irq_n); // R10

  AST_FALL_REQ: assert property (@(posedge clk) disable iff (rst)
    ($fell(strobe) && clr_n) |=> !irq_n); // R9
endmodule

bind latched_port latched_port_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_lo   (sel_lo),
  .sel_hi   (sel_hi),
  .mode_out (mode_out),
  .strobe   (strobe),
  .clr_n    (clr_n),
  .dout     (dout),
  .dout_en  (dout_en),
  .irq_n    (irq_n)
);

// File: tb/latched_port_tb.sv
`timescale 1ns/1ps
module latched_port_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel_lo = 1'b1, sel_hi = 1'b0, mode_out = 1'b0;
  logic         strobe = 1'b0, clr_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         dout_en, irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] m_byte = '0;
  logic         m_flag = 1'b1;
  logic         m_stb  = 1'b0;

  always #5 clk = ~clk;

  latched_port #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .mode_out(mode_out), .strobe(strobe), .clr_n(clr_n),
    .din(din), .dout(dout), .dout_en(dout_en), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic a, input logic b,
                      input logic m, input logic s, input logic c,
                      input logic [W-1:0] d);
    logic sel, ld, oe;
    @(negedge clk);
    sel_lo = a; sel_hi = b; mode_out = m; strobe = s; clr_n = c; din = d;
    @(posedge clk);
    sel = !a && b;
    ld  = m ? sel : s;
    oe  = m || sel;
    if (ld)      m_byte = d;
    else if (!c) m_byte = '0;
    if (!c || sel)     m_flag = 1'b1;
    else if (m_stb && !s) m_flag = 1'b0;
    m_stb = s;
    #1;
    chk(tag, "dout",    32'(dout),    32'(oe ? m_byte : '0));
    chk(tag, "dout_en", 32'(dout_en), 32'(oe));
    chk(tag, "irq_n",   32'(irq_n),   32'(m_flag && !sel));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "dout",    32'(dout),    0);
    chk("R1", "dout_en", 32'(dout_en), 0);
    chk("R1", "irq_n",   32'(irq_n),   1);

    // R2: all select pairs in input mode
    for (int k = 0; k < 4; k++)
      step("R2", k[1], k[0], 1'b0, 1'b0, 1'b1, 8'h11);

    // R3 output mode load, R5 hold while deselected
    step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA5);
    step("R5", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h5A);
    step("R5", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF);

    // R4 input mode strobe load, R7 disabled output
    step("R7", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C);
    step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);

    // R6 clear, then load overriding clear
    step("R6", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h99);
    step("R6", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77);
    step("R6", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);

    // R9 strobe fall raises request, R11 select, R8 select sets flag
    step("R9",  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h21);
    step("R9",  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h22);
    step("R11", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h23);
    step("R8",  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h24);

    // R10 set wins over strobe fall (clear, then select)
    step("R10", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h31);
    step("R10", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h32);
    step("R10", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h33);
    step("R10", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h34);
    step("R8",  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h35);

    // sweep over all control combinations
    lcg = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      step(lcg[26] ? "R3" : "R4", lcg[24], lcg[25], lcg[26], lcg[27],
           lcg[28] | lcg[29], lcg[15:8]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule